// File: doc/BRIEF.md
# Power-Up Self-Test Sequencer

This controller runs the start-up checks of a cryptographic module without any operator involvement. Once a start pulse arrives after reset release, it asks an external hash engine for its known-answer test, then the signature engine for its known-answer test. Only when both pass does it request the run-time firmware digest and compare all 384 bits against a stored reference. A clean run opens the data-path gate, raises a ready flag and posts a pass code. Any failure, whether a reported fail or a missing answer within the step timeout, posts a test-specific error code and freezes the block until reset.

While the module is operational, an on-demand request repeats the digest comparison alone and skips the algorithm tests. The gate stays shut for the whole of every test run. The hash and signature engines, the digest source and the stored reference are outside the block. The block talks to them through level requests and single-cycle done/pass strobes.

Top module: `selftest_seq`

## Requirements
- R1: After reset, status_o is 32'h0, data_en_o and ready_o are 0, and no request output is high.
- R2: No test starts before start_i. The first start_i pulse after reset raises only hash_req_o on the next cycle.
- R3: Only one request is high at a time. sig_req_o rises only after a passing hash result. dig_req_o rises only after a passing signature result, or from the operational state.
- R4: Whenever a request is high, data_en_o and ready_o are 0 and status_o reads 32'h0.
- R5: When the digest matches, status_o becomes 32'h5A5A0001 in the same cycle that data_en_o and ready_o both rise.
- R6: A hash fail result gives status 32'hAA0000FB. A signature fail result gives 32'hAA0000FC.
- R7: A mismatch in any bit of the 384-bit digest, including bit 0 and bit 383, gives status 32'hAA0000FD.
- R8: Each step fails with its own error code if no done arrives within TIMEOUT_CYC cycles of entering it. A done in the cycle the timeout expires still counts, and one cycle later it does not.
- R9: In the error state all inputs are ignored. The first error code stays on status_o and the gate stays shut until reset.
- R10: ondemand_i in the operational state shuts the gate, clears status to 0 and runs only the digest comparison. It ends in the pass code or 32'hAA0000FD.
- R11: start_i, ondemand_i and done strobes of other steps have no effect while a test is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse after reset release |
| ondemand_i | input | 1 | On-demand integrity re-check request |
| hash_req_o | output | 1 | Hash known-answer test request (level) |
| hash_done_i | input | 1 | Hash test finished strobe |
| hash_pass_i | input | 1 | Hash test result, valid with done |
| sig_req_o | output | 1 | Signature known-answer test request (level) |
| sig_done_i | input | 1 | Signature test finished strobe |
| sig_pass_i | input | 1 | Signature test result, valid with done |
| dig_req_o | output | 1 | Firmware digest request (level) |
| dig_done_i | input | 1 | Digest valid strobe |
| dig_calc_i | input | 384 | Digest computed at run time |
| dig_ref_i | input | 384 | Stored reference digest |
| status_o | output | 32 | 0 while testing, pass code or error code |
| data_en_o | output | 1 | Data-path output enable |
| ready_o | output | 1 | Module operational flag |

## Verification
Two events can land in the same cycle: a step's done strobe and the expiry of that step's timeout counter. With the timeout shortened to 20 cycles, the bench delays a stub's answer to exactly the expiry cycle, and the step is judged a pass. It then delays the answer by one more cycle, and the step is judged a failure with that step's code while the late strobe is ignored. A second overlap, a stray start or on-demand pulse during a running test, is injected alongside other steps' done strobes, and the bench checks that the sequence order and the final code are unchanged.

// File: rtl/selftest_pkg.sv
// Shared definitions for the self-test sequencer: step encoding and status codes.
// Assumes a 32-bit status word seen by the rest of the chip.
package selftest_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_HASH  = 3'd1,
        ST_SIG   = 3'd2,
        ST_INTEG = 3'd3,
        ST_OPER  = 3'd4,
        ST_ERR   = 3'd5
    } step_e;

    localparam logic [31:0] CODE_BUSY      = 32'h0000_0000;
    localparam logic [31:0] CODE_PASS      = 32'h5A5A_0001;
    localparam logic [31:0] CODE_HASH_FAIL = 32'hAA00_00FB;
    localparam logic [31:0] CODE_SIG_FAIL  = 32'hAA00_00FC;
    localparam logic [31:0] CODE_INT_FAIL  = 32'hAA00_00FD;

endpackage

// File: rtl/selftest_step_timer.sv
// Per-step watchdog counter. It counts cycles while a test step is active and
// flags expiry after LIMIT cycles in the step.
// Assumes clr_i pulses on every step change, so each step gets a fresh window.
module selftest_step_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    // Count cycles spent in the current step, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (run_i && !expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired_o = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/selftest_digest_cmp.sv
// Wide digest equality check split into lanes. Each lane compares one slice and
// the lane results are AND-reduced.
// Assumes DIG_W is a multiple of LANE_W. The result is combinational and is
// sampled by the controller on the digest done strobe.
module selftest_digest_cmp #(
    parameter int DIG_W  = 384,
    parameter int LANE_W = 32
) (
    input  logic [DIG_W-1:0] calc_i,
    input  logic [DIG_W-1:0] ref_i,
    output logic             match_o
);
    localparam int LANES = DIG_W / LANE_W;

    logic [LANES-1:0] lane_eq;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Compare one slice of the digest.
        assign lane_eq[g] = (calc_i[g*LANE_W +: LANE_W] == ref_i[g*LANE_W +: LANE_W]);
    end

    assign match_o = &lane_eq;

endmodule

// File: rtl/selftest_ctrl.sv
// Sequencing state machine: hash test, then signature test, then digest check,
// then operational state. It also handles the on-demand digest re-check and a
// sticky error state.
// Assumes done strobes are single-cycle and that a done has priority over a
// timeout expiring in the same cycle.
module selftest_ctrl
    import selftest_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic        ondemand_i,
    input  logic        hash_done_i,
    input  logic        hash_pass_i,
    input  logic        sig_done_i,
    input  logic        sig_pass_i,
    input  logic        dig_done_i,
    input  logic        dig_match_i,
    input  logic        expired_i,
    output logic        test_active_o,
    output logic        step_chg_o,
    output logic        hash_req_o,
    output logic        sig_req_o,
    output logic        dig_req_o,
    output logic [31:0] status_o,
    output logic        data_en_o,
    output logic        ready_o
);
    step_e       state_q, state_d;
    logic [31:0] status_q, status_d;

    // Next-step and status decision for the current step.
    always_comb begin
        state_d  = state_q;
        status_d = status_q;
        case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d  = ST_HASH;
                    status_d = CODE_BUSY;
                end
            end
            ST_HASH: begin
                if (hash_done_i) begin
                    if (hash_pass_i) begin
                        state_d = ST_SIG;
                    end else begin
                        state_d  = ST_ERR;
                        status_d = CODE_HASH_FAIL;
                    end
                end else if (expired_i) begin
                    state_d  = ST_ERR;
                    status_d = CODE_HASH_FAIL;
                end
            end
            ST_SIG: begin
                if (sig_done_i) begin
                    if (sig_pass_i) begin
                        state_d = ST_INTEG;
                    end else begin
                        state_d  = ST_ERR;
                        status_d = CODE_SIG_FAIL;
                    end
                end else if (expired_i) begin
                    state_d  = ST_ERR;
                    status_d = CODE_SIG_FAIL;
                end
            end
            ST_INTEG: begin
                if (dig_done_i) begin
                    if (dig_match_i) begin
                        state_d  = ST_OPER;
                        status_d = CODE_PASS;
                    end else begin
                        state_d  = ST_ERR;
                        status_d = CODE_INT_FAIL;
                    end
                end else if (expired_i) begin
                    state_d  = ST_ERR;
                    status_d = CODE_INT_FAIL;
                end
            end
            ST_OPER: begin
                if (ondemand_i) begin
                    state_d  = ST_INTEG;
                    status_d = CODE_BUSY;
                end
            end
            ST_ERR: begin
                state_d = ST_ERR;
            end
            default: begin
                state_d  = ST_ERR;
                status_d = CODE_INT_FAIL;
            end
        endcase
    end

    // State and status registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            status_q <= CODE_BUSY;
        end else begin
            state_q  <= state_d;
            status_q <= status_d;
        end
    end

    assign step_chg_o    = (state_d != state_q);
    assign test_active_o = (state_q == ST_HASH) || (state_q == ST_SIG) || (state_q == ST_INTEG);
    assign hash_req_o    = (state_q == ST_HASH);
    assign sig_req_o     = (state_q == ST_SIG);
    assign dig_req_o     = (state_q == ST_INTEG);
    assign data_en_o     = (state_q == ST_OPER);
    assign ready_o       = (state_q == ST_OPER);
    assign status_o      = status_q;

endmodule

// File: rtl/selftest_seq.sv
// Top of the power-up self-test sequencer. It wires the controller, the per-step
// timeout counter and the wide digest comparator together.
// Assumes the external engines hold their results until they strobe done.
module selftest_seq #(
    parameter int DIG_W       = 384,
    parameter int LANE_W      = 32,
    parameter int TIMEOUT_CYC = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             ondemand_i,
    output logic             hash_req_o,
    input  logic             hash_done_i,
    input  logic             hash_pass_i,
    output logic             sig_req_o,
    input  logic             sig_done_i,
    input  logic             sig_pass_i,
    output logic             dig_req_o,
    input  logic             dig_done_i,
    input  logic [DIG_W-1:0] dig_calc_i,
    input  logic [DIG_W-1:0] dig_ref_i,
    output logic [31:0]      status_o,
    output logic             data_en_o,
    output logic             ready_o
);
    logic dig_match;
    logic expired;
    logic test_active;
    logic step_chg;

    selftest_digest_cmp #(
        .DIG_W  (DIG_W),
        .LANE_W (LANE_W)
    ) u_cmp (
        .calc_i  (dig_calc_i),
        .ref_i   (dig_ref_i),
        .match_o (dig_match)
    );

    selftest_step_timer #(
        .LIMIT (TIMEOUT_CYC)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (test_active),
        .clr_i     (step_chg),
        .expired_o (expired)
    );

    selftest_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .ondemand_i    (ondemand_i),
        .hash_done_i   (hash_done_i),
        .hash_pass_i   (hash_pass_i),
        .sig_done_i    (sig_done_i),
        .sig_pass_i    (sig_pass_i),
        .dig_done_i    (dig_done_i),
        .dig_match_i   (dig_match),
        .expired_i     (expired),
        .test_active_o (test_active),
        .step_chg_o    (step_chg),
        .hash_req_o    (hash_req_o),
        .sig_req_o     (sig_req_o),
        .dig_req_o     (dig_req_o),
        .status_o      (status_o),
        .data_en_o     (data_en_o),
        .ready_o       (ready_o)
    );

endmodule

// File: rtl/selftest_seq_chk.sv
// Port-level checker for the self-test sequencer, bound to every instance.
// Assumes synchronous active-low reset held for at least one clock.
module selftest_seq_chk #(
    parameter int DIG_W = 384
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ondemand_i,
    input logic             hash_req_o,
    input logic             hash_done_i,
    input logic             hash_pass_i,
    input logic             sig_req_o,
    input logic             sig_done_i,
    input logic             sig_pass_i,
    input logic             dig_req_o,
    input logic             dig_done_i,
    input logic [DIG_W-1:0] dig_calc_i,
    input logic [DIG_W-1:0] dig_ref_i,
    input logic [31:0]      status_o,
    input logic             data_en_o,
    input logic             ready_o
);
    logic any_req;
    logic is_err;
    assign any_req = hash_req_o || sig_req_o || dig_req_o;
    assign is_err  = (status_o == 32'hAA00_00FB) || (status_o == 32'hAA00_00FC) ||
                     (status_o == 32'hAA00_00FD);

    // R3
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hash_req_o, sig_req_o, dig_req_o}));

    // R3
    sig_after_hash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_req_o) |-> $past(hash_req_o));

    // R3
    dig_after_sig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dig_req_o) |-> ($past(sig_req_o) || $past(data_en_o)));

    // R4
    gate_shut_in_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> (!data_en_o && !ready_o && status_o == 32'h0));

    // R5
    gate_means_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_en_o |-> (ready_o && status_o == 32'h5A5A_0001));

    // R6
    hash_fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hash_req_o && hash_done_i && !hash_pass_i) |=> status_o == 32'hAA00_00FB);

    // R6
    sig_fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_req_o && sig_done_i && !sig_pass_i) |=> status_o == 32'hAA00_00FC);

    // R7
    dig_mismatch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dig_req_o && dig_done_i && (dig_calc_i != dig_ref_i)) |=> status_o == 32'hAA00_00FD);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        is_err |=> ($stable(status_o) && !data_en_o && !any_req));

    // R10
    ondemand_integ_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en_o && ondemand_i) |=> (dig_req_o && !hash_req_o && !sig_req_o && !data_en_o));

endmodule

bind selftest_seq selftest_seq_chk #(.DIG_W(DIG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ondemand_i  (ondemand_i),
    .hash_req_o  (hash_req_o),
    .hash_done_i (hash_done_i),
    .hash_pass_i (hash_pass_i),
    .sig_req_o   (sig_req_o),
    .sig_done_i  (sig_done_i),
    .sig_pass_i  (sig_pass_i),
    .dig_req_o   (dig_req_o),
    .dig_done_i  (dig_done_i),
    .dig_calc_i  (dig_calc_i),
    .dig_ref_i   (dig_ref_i),
    .status_o    (status_o),
    .data_en_o   (data_en_o),
    .ready_o     (ready_o)
);

// File: tb/selftest_seq_test.sv
// Bench for the self-test sequencer: a vector table of stub responses walked by
// one loop, then directed tests for reset, ignored inputs and on-demand checks.
module selftest_seq_test;
    localparam int DW = 384;
    localparam int TO = 20;
    localparam int NV = 11;
    localparam logic [31:0] PASS = 32'h5A5A_0001;
    localparam logic [31:0] EFB  = 32'hAA00_00FB;
    localparam logic [31:0] EFC  = 32'hAA00_00FC;
    localparam logic [31:0] EFD  = 32'hAA00_00FD;

    // Fields: hash delay[67:60], hash ok[59], sig delay[58:51], sig ok[50],
    // dig delay[49:42], dig mismatch[41], flipped bit[40:32], expected[31:0].
    // A delay of 255 means the stub never answers.
    localparam logic [67:0] VEC [NV] = '{
        {8'd0,   1'b1, 8'd0,   1'b1, 8'd0,   1'b0, 9'd0,   PASS},
        {8'd3,   1'b1, 8'd5,   1'b1, 8'd7,   1'b0, 9'd0,   PASS},
        {8'd2,   1'b0, 8'd0,   1'b1, 8'd0,   1'b0, 9'd0,   EFB},
        {8'd0,   1'b1, 8'd4,   1'b0, 8'd0,   1'b0, 9'd0,   EFC},
        {8'd0,   1'b1, 8'd0,   1'b1, 8'd2,   1'b1, 9'd0,   EFD},
        {8'd0,   1'b1, 8'd0,   1'b1, 8'd0,   1'b1, 9'd383, EFD},
        {8'd255, 1'b1, 8'd0,   1'b1, 8'd0,   1'b0, 9'd0,   EFB},
        {8'd0,   1'b1, 8'd255, 1'b1, 8'd0,   1'b0, 9'd0,   EFC},
        {8'd0,   1'b1, 8'd0,   1'b1, 8'd255, 1'b0, 9'd0,   EFD},
        {8'd20,  1'b1, 8'd20,  1'b1, 8'd20,  1'b0, 9'd0,   PASS},
        {8'd0,   1'b1, 8'd21,  1'b1, 8'd0,   1'b0, 9'd0,   EFC}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic start = 1'b0, od = 1'b0;
    logic hd = 1'b0, hp = 1'b0, sd = 1'b0, sp = 1'b0, dd = 1'b0;
    logic [DW-1:0] calc, ref_v;
    logic hash_req, sig_req, dig_req, data_en, ready;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;

    selftest_seq #(.DIG_W(DW), .LANE_W(32), .TIMEOUT_CYC(TO)) uut (
        .clk (clk), .rst_n (rst_n), .start_i (start), .ondemand_i (od),
        .hash_req_o (hash_req), .hash_done_i (hd), .hash_pass_i (hp),
        .sig_req_o (sig_req), .sig_done_i (sd), .sig_pass_i (sp),
        .dig_req_o (dig_req), .dig_done_i (dd), .dig_calc_i (calc), .dig_ref_i (ref_v),
        .status_o (status), .data_en_o (data_en), .ready_o (ready)
    );

    task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk1(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0; start = 0; od = 0; hd = 0; hp = 0; sd = 0; sp = 0; dd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic kick();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    function automatic logic req_of(input int which);
        return (which == 0) ? hash_req : (which == 1) ? sig_req : dig_req;
    endfunction

    task automatic wait_req(input int which, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            if (req_of(which)) begin
                seen = 1'b1;
                return;
            end
            @(negedge clk);
        end
    endtask

    // Wait for a step's request, then answer after dly cycles (255 = never).
    task automatic run_step(input int which, input int dly, input logic ok);
        bit seen;
        wait_req(which, seen);
        if (!seen || dly == 255) return;
        repeat (dly) @(negedge clk);
        case (which)
            0: begin hd = 1'b1; hp = ok; end
            1: begin sd = 1'b1; sp = ok; end
            default: dd = 1'b1;
        endcase
        @(negedge clk);
        hd = 0; hp = 0; sd = 0; sp = 0; dd = 0;
    endtask

    function automatic string tag_of(input int v);
        case (v)
            0, 1:       return "R5";
            2, 3:       return "R6";
            4, 5:       return "R7";
            default:    return "R8";
        endcase
    endfunction

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [67:0] e;
        ref_v = {12{32'h3C96_A50F}} ^ {DW/2{2'b01}};
        calc  = ref_v;

        // R1: reset state
        apply_reset();
        @(negedge clk);
        chk32("R1", status, 32'h0);
        chk1("R1", data_en, 1'b0);
        chk1("R1", ready, 1'b0);
        chk1("R1", hash_req | sig_req | dig_req, 1'b0);

        // R2: nothing starts without start_i
        repeat (10) @(negedge clk);
        chk1("R2", hash_req, 1'b0);
        kick();
        chk1("R2", hash_req, 1'b1);
        chk1("R2", sig_req | dig_req, 1'b0);
        chk32("R4", status, 32'h0);
        chk1("R4", data_en, 1'b0);

        // Vector table walk
        for (int v = 0; v < NV; v++) begin
            e = VEC[v];
            calc = ref_v ^ (DW'(e[41]) << e[40:32]);
            apply_reset();
            kick();
            run_step(0, int'(e[67:60]), e[59]);
            run_step(1, int'(e[58:51]), e[50]);
            run_step(2, int'(e[49:42]), 1'b1);
            repeat (TO + 5) @(negedge clk);
            chk32(tag_of(v), status, e[31:0]);
            chk1(tag_of(v), data_en, e[31:0] == PASS);
            chk1("R5", ready, e[31:0] == PASS);
        end

        // R11: stray start, ondemand and other done strobes during hash test
        calc = ref_v;
        apply_reset();
        kick();
        start = 1; od = 1; sd = 1; sp = 1; dd = 1;
        @(negedge clk);
        start = 0; od = 0; sd = 0; sp = 0; dd = 0;
        chk1("R11", hash_req, 1'b1);
        chk1("R11", sig_req | dig_req, 1'b0);
        run_step(0, 2, 1'b1);
        chk1("R11", sig_req, 1'b1);
        run_step(1, 1, 1'b1);
        run_step(2, 1, 1'b1);
        @(negedge clk);
        chk32("R11", status, PASS);

        // R10: on-demand digest re-check from operational state
        od = 1;
        @(negedge clk);
        od = 0;
        chk1("R10", dig_req, 1'b1);
        chk1("R10", hash_req | sig_req, 1'b0);
        chk1("R10", data_en | ready, 1'b0);
        chk32("R10", status, 32'h0);
        run_step(2, 3, 1'b1);
        @(negedge clk);
        chk32("R10", status, PASS);
        chk1("R10", ready, 1'b1);
        calc = ref_v ^ (DW'(1) << 200);
        od = 1;
        @(negedge clk);
        od = 0;
        run_step(2, 0, 1'b1);
        @(negedge clk);
        chk32("R10", status, EFD);
        chk1("R10", data_en, 1'b0);

        // R9: error state ignores everything
        start = 1; od = 1; hd = 1; hp = 1; sd = 1; sp = 1; dd = 1;
        calc = ref_v;
        repeat (3) @(negedge clk);
        start = 0; od = 0; hd = 0; hp = 0; sd = 0; sp = 0; dd = 0;
        repeat (5) @(negedge clk);
        chk32("R9", status, EFD);
        chk1("R9", data_en | ready, 1'b0);
        chk1("R9", hash_req | sig_req | dig_req, 1'b0);

        // R1: reset clears the error, then a full clean run passes
        apply_reset();
        @(negedge clk);
        chk32("R1", status, 32'h0);
        kick();
        run_step(0, 0, 1'b1);
        run_step(1, 0, 1'b1);
        run_step(2, 0, 1'b1);
        @(negedge clk);
        chk32("R5", status, PASS);
        chk1("R5", data_en & ready, 1'b1);

        report();
        $finish;
    end

endmodule